// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that sits around a successive-approximation converter. Software programs it through a byte-wide register port holding three control words: a main control/status word, a trigger-source word and a timing word. A conversion begins when software writes the start bit, or, with auto-triggering enabled, on a rising edge of one selected trigger input. The controller then steps through an analog warm-up interval, a sampling window and one decision cycle per result bit. All three are counted in converter clock periods, and the converter clock is a divided enable derived from the system clock.

When the last decision cycle ends, the word on the digital result input is captured into a two-byte result register. A completion flag is then raised, and it drives an interrupt request when the interrupt enable bit and the global enable input are both high. The flag is cleared either by an acknowledge pulse or by software writing a one to it. The analog front end is replaced by the result input. The result leaves through the register port and there is no streaming handshake, so all pins are plain control and status signals.

The converter clock is a one-cycle enable from a counter that restarts at each accepted start. A conversion therefore takes exactly (warm-up + 1 + sample + 2 + RES_W) × divisor system cycles, counted from the clock edge that accepts the start to the edge that sets the flag.

Top module: `adcs_conv_ctrl`

## Requirements
- R1: After reset the control word (address 0) and the trigger word (address 1) read 8'h00, the timing word (address 2) reads 8'h55, both result bytes (addresses 3 and 4) read 8'h00, and irq is low.
- R2: The control word bits 2:0 select the converter clock divisor as 000→2, 001→2, 010→4, 011→8, 100→16, 101→32, 110→64, 111→128. The timing word holds the warm-up count in bits 5:0 and the sample count in bits 7:6. The flag is set exactly (warm-up+1 + sample+2 + RES_W) × divisor system cycles after the edge that accepts a start.
- R3: Writing a one to control bit 6 while idle starts a conversion. Bit 6 reads one while a conversion runs and zero once it has completed.
- R4: With control bit 5 set, a rising edge of the selected trigger starts a conversion. A trigger held high starts no further conversion. With bit 5 clear, trigger edges are ignored.
- R5: Trigger word bits 2:0 pick trigger input n. Edges on the other inputs are ignored, and a code at or above NUM_TRIG selects no source.
- R6: While a conversion runs, trigger edges and start writes are ignored, and the running conversion completes at its original time.
- R7: At completion the result input is latched: its bits 7:0 read at address 3 and its upper bits read at address 4, bits 1:0. The latched value does not follow later changes of the input.
- R8: Control bit 4 (completion flag) is set only by a completion. irq is high exactly when the flag, control bit 3 and the gie input are all high.
- R9: The flag is cleared by an irq_ack pulse or by writing control bit 4 as one, and writing it as zero leaves it set. A read-modify-write of the control word that copies back a set flag therefore clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address (0 control, 1 trigger, 2 timing, 3 result low, 4 result high) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| trig_in | input | NUM_TRIG | Auto-trigger sources, synchronous to clk |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| conv_sample | input | RES_W | Digital stand-in for the converter result |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The bench builds the block with RES_W=10 and NUM_TRIG=4. With only four sources behind a 3-bit select field, codes 4 to 7 point at nothing, so the out-of-range select case can be reached. A scoreboard predicts each completion cycle from the divisor and the timing word. It covers both codes that give a divide-by-2, the largest divisor, and the timing word at all-zeros, all-ones and its reset value, so both counters are exercised at their extremes.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_SAMP = 2'd2,
    PH_BITS = 2'd3
  } phase_e;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_TRIG   = 3'd1;
  localparam logic [2:0] ADR_TIME   = 3'd2;
  localparam logic [2:0] ADR_RES_LO = 3'd3;
  localparam logic [2:0] ADR_RES_HI = 3'd4;

  localparam int B_START = 6;
  localparam int B_AUTO  = 5;
  localparam int B_FLAG  = 4;
  localparam int B_IEN   = 3;

endpackage

// File: rtl/adcs_prescale.sv
module adcs_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   pow;

  always_comb begin
    pow = (CNT_W+1)'(1) << ps_sel;
    if (ps_sel == '0) lim = CNT_W'(1);
    else              lim = CNT_W'(pow - (CNT_W+1)'(1));
  end

  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adcs_trigger.sv
module adcs_trigger #(
  parameter int NUM_TRIG = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  logic                en,
  output logic                edge_o
);
  logic cur;
  logic prev_q;

  always_comb begin
    cur = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel == SEL_W'(i)) cur = trig_in[i];
    end
  end

  assign edge_o = en && cur && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  // R4
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

endmodule

// File: rtl/adcs_phase.sv
module adcs_phase
  import adcs_pkg::*;
#(
  parameter int SU_W = 6,
  parameter int TH_W = 2,
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [SU_W-1:0] su,
  input  logic [TH_W-1:0] tht,
  output logic            busy,
  output logic            done
);
  localparam int BW  = $clog2(BITS + 1);
  localparam int CW0 = (SU_W > TH_W + 1) ? SU_W : TH_W + 1;
  localparam int CW  = (CW0 > BW) ? CW0 : BW;

  phase_e        state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = tick && (cnt_q == '0);
  assign busy = (state_q != PH_IDLE);
  assign done = (state_q == PH_BITS) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PH_IDLE: if (start) begin
          state_q <= PH_WARM;
          cnt_q   <= CW'(su);
        end
        PH_WARM: if (last) begin
          state_q <= PH_SAMP;
          cnt_q   <= CW'(tht) + CW'(1);
        end else if (tick) cnt_q <= cnt_q - CW'(1);
        PH_SAMP: if (last) begin
          state_q <= PH_BITS;
          cnt_q   <= CW'(BITS - 1);
        end else if (tick) cnt_q <= cnt_q - CW'(1);
        default: if (last) begin
          state_q <= PH_IDLE;
          cnt_q   <= '0;
        end else if (tick) cnt_q <= cnt_q - CW'(1);
      endcase
    end
  end

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/adcs_regs.sv
module adcs_regs
  import adcs_pkg::*;
#(
  parameter int         RES_W     = 10,
  parameter int         SEL_W     = 3,
  parameter logic [7:0] TIME_INIT = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [RES_W-1:0] sample,
  input  logic             irq_ack,
  input  logic             gie,
  output logic             irq,
  output logic             sw_start,
  output logic             auto_en,
  output logic [SEL_W-1:0] trig_sel,
  output logic [2:0]       ps_sel,
  output logic [5:0]       su_time,
  output logic [1:0]       th_time
);
  logic             ate_q, flag_q, ien_q;
  logic [2:0]       ps_q;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       time_q;
  logic [RES_W-1:0] data_q;
  logic [15:0]      data_ext;
  logic             wr_ctrl;

  assign wr_ctrl  = wr && (addr == ADR_CTRL);
  assign sw_start = wr_ctrl && wdata[B_START];
  assign auto_en  = ate_q;
  assign trig_sel = sel_q;
  assign ps_sel   = ps_q;
  assign su_time  = time_q[5:0];
  assign th_time  = time_q[7:6];
  assign irq      = flag_q && ien_q && gie;
  assign data_ext = 16'(data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ate_q  <= 1'b0;
      ien_q  <= 1'b0;
      ps_q   <= '0;
      sel_q  <= '0;
      time_q <= TIME_INIT;
    end else if (wr) begin
      case (addr)
        ADR_CTRL: begin
          ate_q <= wdata[B_AUTO];
          ien_q <= wdata[B_IEN];
          ps_q  <= wdata[2:0];
        end
        ADR_TRIG: sel_q  <= wdata[SEL_W-1:0];
        ADR_TIME: time_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   flag_q <= 1'b0;
    else if (done)                                flag_q <= 1'b1;
    else if (irq_ack || (wr_ctrl && wdata[B_FLAG])) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (done) data_q <= sample;
  end

  always_comb begin
    case (addr)
      ADR_CTRL:   rdata = {1'b0, busy, ate_q, flag_q, ien_q, ps_q};
      ADR_TRIG:   rdata = 8'(sel_q);
      ADR_TIME:   rdata = time_q;
      ADR_RES_LO: rdata = data_ext[7:0];
      ADR_RES_HI: rdata = data_ext[15:8];
      default:    rdata = 8'h00;
    endcase
  end

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(done));

  // R9
  flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && irq_ack && !done) |=> !flag_q);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data_q));

endmodule

// File: rtl/adcs_conv_ctrl.sv
module adcs_conv_ctrl #(
  parameter int RES_W    = 10,
  parameter int NUM_TRIG = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                gie,
  input  logic                irq_ack,
  input  logic [RES_W-1:0]    conv_sample,
  output logic                irq
);
  logic             busy, done, tick, trig_edge, sw_start, auto_en;
  logic [SEL_W-1:0] trig_sel;
  logic [2:0]       ps_sel;
  logic [5:0]       su_time;
  logic [1:0]       th_time;

  adcs_regs #(.RES_W(RES_W), .SEL_W(SEL_W), .TIME_INIT(8'h55)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done(done), .sample(conv_sample),
    .irq_ack(irq_ack), .gie(gie), .irq(irq), .sw_start(sw_start),
    .auto_en(auto_en), .trig_sel(trig_sel), .ps_sel(ps_sel),
    .su_time(su_time), .th_time(th_time)
  );

  adcs_trigger #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(trig_sel),
    .en(auto_en), .edge_o(trig_edge)
  );

  adcs_prescale #(.PS_W(3)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .ps_sel(ps_sel), .tick(tick)
  );

  adcs_phase #(.SU_W(6), .TH_W(2), .BITS(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(sw_start || trig_edge), .tick(tick),
    .su(su_time), .tht(th_time), .busy(busy), .done(done)
  );

endmodule

// File: tb/adcs_conv_ctrl_tb.sv
module adcs_conv_ctrl_tb;
  localparam int RES_W = 10;
  localparam int NT    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic [NT-1:0]    trig_in = '0;
  logic             gie = 1'b1;
  logic             irq_ack = 1'b0;
  logic [RES_W-1:0] conv_sample = '0;
  logic             irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];
  bit mon_on = 1'b1;
  logic irq_prev = 1'b0;

  adcs_conv_ctrl #(.RES_W(RES_W), .NUM_TRIG(NT), .SEL_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .gie(gie), .irq_ack(irq_ack), .conv_sample(conv_sample), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each irq rise is a completion, compared to the predicted cycle
  always @(posedge clk) begin
    #2;
    if (irq && !irq_prev && mon_on) begin
      if (exp_q.size() == 0) check("R6 unexpected completion", cyc, -1);
      else check("R2 completion cycle", cyc, exp_q.pop_front());
    end
    irq_prev = irq;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_reg(string req, logic [2:0] a, logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), int'(e));
  endtask

  function automatic int conv_len(logic [7:0] t);
    return int'(t[5:0]) + 1 + int'(t[7:6]) + 2 + RES_W;
  endfunction

  function automatic int div_of(logic [2:0] p);
    return (p == 3'd0) ? 2 : (1 << p);
  endfunction

  task automatic start_sw(logic [7:0] a, logic [7:0] t);
    wr(3'd0, a | 8'h40);
    exp_q.push_back(cyc + conv_len(t) * div_of(a[2:0]));
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    int n = 0;
    do begin
      rd(3'd0, v);
      n++;
    end while (v[6] && n < 20000);
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] tv [4];
    logic [2:0] pv [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1 ctrl reset", 3'd0, 8'h00);
    expect_reg("R1 trig reset", 3'd1, 8'h00);
    expect_reg("R1 time reset", 3'd2, 8'h55);
    expect_reg("R1 res lo reset", 3'd3, 8'h00);
    expect_reg("R1 res hi reset", 3'd4, 8'h00);
    check("R1 irq reset", int'(irq), 0);

    // R3 software start with reset timing word, divisor 2
    conv_sample = 10'h2A7;
    wr(3'd0, 8'h08);
    start_sw(8'h08, 8'h55);
    idle_cycles(10);
    rd(3'd0, v);
    check("R3 busy while running", int'(v[6]), 1);
    wait_idle();
    expect_reg("R3 R8 ctrl after completion", 3'd0, 8'h18);
    expect_reg("R7 result low", 3'd3, 8'hA7);
    expect_reg("R7 result high", 3'd4, 8'h02);
    check("R8 irq with flag ie gie", int'(irq), 1);
    conv_sample = 10'h155;
    expect_reg("R7 result holds", 3'd3, 8'hA7);

    // R9 write zero keeps, R8 gie gating, irq_ack clears
    mon_on = 1'b0;
    wr(3'd0, 8'h08);
    expect_reg("R9 write zero keeps flag", 3'd0, 8'h18);
    @(negedge clk) gie = 1'b0;
    #1 check("R8 irq low without gie", int'(irq), 0);
    @(negedge clk) gie = 1'b1;
    #1 check("R8 irq back with gie", int'(irq), 1);
    @(negedge clk) irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    expect_reg("R9 ack clears flag", 3'd0, 8'h08);
    check("R9 irq low after ack", int'(irq), 0);
    idle_cycles(2);
    mon_on = 1'b1;

    // R2 divisor 8, timing word 0x82, then read-modify-write hazard
    conv_sample = 10'h3FF;
    wr(3'd2, 8'h82);
    wr(3'd0, 8'h0B);
    start_sw(8'h0B, 8'h82);
    wait_idle();
    expect_reg("R7 result low full", 3'd3, 8'hFF);
    expect_reg("R7 result high full", 3'd4, 8'h03);
    rd(3'd0, v);
    check("R8 flag set before rmw", int'(v), 8'h1B);
    wr(3'd0, v);
    expect_reg("R9 rmw write-back clears flag", 3'd0, 8'h0B);

    // R2 sweep of divisors and timing extremes
    pv[0] = 3'd1; tv[0] = 8'h00;
    pv[1] = 3'd7; tv[1] = 8'h00;
    pv[2] = 3'd5; tv[2] = 8'hFF;
    pv[3] = 3'd2; tv[3] = 8'h41;
    for (int k = 0; k < 4; k++) begin
      conv_sample = RES_W'(10'h0C3 + k * 10'h051);
      wr(3'd2, tv[k]);
      wr(3'd0, {5'b00001, pv[k]});
      start_sw({5'b00001, pv[k]}, tv[k]);
      wait_idle();
      rd(3'd3, v);
      check("R7 sweep result low", int'(v), int'(conv_sample[7:0]));
      wr(3'd0, {5'b00011, pv[k]});
      expect_reg("R9 write one clears flag", 3'd0, {5'b00001, pv[k]});
    end

    // R4 R5 auto trigger on source 2, divisor 2, timing 0x00
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h28);
    @(negedge clk) trig_in[1] = 1'b1;
    idle_cycles(40);
    expect_reg("R5 unselected source ignored", 3'd0, 8'h28);
    conv_sample = 10'h1E4;
    @(negedge clk) trig_in[2] = 1'b1;
    @(posedge clk); #1 exp_q.push_back(cyc + 13 * 2);
    idle_cycles(5);
    // R6 retrigger and start write while busy
    @(negedge clk) trig_in[2] = 1'b0;
    @(negedge clk) trig_in[2] = 1'b1;
    wr(3'd0, 8'h68);
    wait_idle();
    expect_reg("R4 trigger conversion result", 3'd3, 8'hE4);
    expect_reg("R4 flag after trigger", 3'd0, 8'h38);
    wr(3'd0, 8'h38);
    idle_cycles(60);
    expect_reg("R4 held trigger no restart", 3'd0, 8'h28);

    // R4 auto-trigger disabled
    wr(3'd0, 8'h08);
    @(negedge clk) trig_in[2] = 1'b0;
    @(negedge clk) trig_in[2] = 1'b1;
    idle_cycles(60);
    expect_reg("R4 edge ignored when disabled", 3'd0, 8'h08);

    // R5 select code beyond NUM_TRIG
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h28);
    @(negedge clk) trig_in = '0;
    @(negedge clk) trig_in = '1;
    idle_cycles(60);
    expect_reg("R5 out of range select", 3'd0, 8'h28);

    idle_cycles(4);
    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule